// File: doc/BRIEF.md
# USB Host Frame Transaction Scheduler

This block paces a USB host port frame by frame. Each pulse on `frame_tick` marks a frame boundary. On that pulse the block advances an 11-bit frame number and raises a one-cycle request toward the packet layer. The request is a start-of-frame token when the attached device runs at full speed, or a keep-alive K-state when it runs at low speed. Packet generation and line signalling are handled elsewhere.

After each boundary the block walks its endpoint slots in passes and hands out one transaction grant at a time. Every slot has its own configuration: transfer kind, interval field and direction, plus activity flags from the endpoint's buffer logic. Bulk slots are granted on any pass while they are active. Interrupt and isochronous slots are granted only on the first pass of a frame, and only in frames where their private interval counter stands at zero. A grant is held until the packet engine returns `xact_done`.

Top module: `usb_frame_sched`

## Requirements
- R1: After reset `frame_num` is 0. Each cycle with `frame_tick` high adds one to `frame_num` in the following cycle. The count wraps from 2047 to 0.
- R2: In the cycle after `frame_tick`, exactly one of two requests pulses for one cycle. `sof_req` pulses if `low_speed` was 0, and `keepalive_req` pulses if `low_speed` was 1. The two are never high together.
- R3: Each slot's 2-bit type field in `ep_type[2i+1:2i]` selects its kind: 00 unused, 01 bulk, 10 interrupt, 11 isochronous. An unused slot is never granted, whatever its flags.
- R4: A slot with `ep_dir_in` 1 (receive) is active when its `ep_rx_req` bit is set. A slot with `ep_dir_in` 0 (transmit) is active when its `ep_tx_rdy` or `ep_tx_fifo_ne` bit is set. The other flags have no effect on the slot.
- R5: An active bulk slot is granted on every scan pass, including passes after the first in a frame.
- R6: For an interrupt slot, the 8-bit field `ep_interval[8i+7:8i]` holds a period N from 1 to 255 frames, and 0 is treated as 1. The slot is due in the first frame after reset and then every N frames.
- R7: For an isochronous slot, the same field holds an exponent e. The slot is due every 2^e frames, with e clamped to 16, starting with the first frame after reset.
- R8: An interrupt or isochronous slot is granted only on the first scan pass of a frame in which it is due. It is granted at most once in that pass.
- R9: Slots are examined in ascending index order, wrapping to 0 after the last one. Only one grant is open at a time. `grant` stays high with `grant_ep` unchanged until `xact_done` is seen, and the scan then resumes at the next index.
- R10: No grant is issued after reset until the first `frame_tick`.
- R11: A `frame_tick` that arrives while a grant is open leaves that grant untouched. When `xact_done` arrives, in the same cycle as the tick or later, the scan restarts at index 0 as the new frame's first pass. A tick during scanning restarts the pass at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| low_speed | input | 1 | 1: low-speed device attached, 0: full speed |
| ep_type | input | 2*NUM_EP | Per-slot transfer kind (00 unused, 01 bulk, 10 interrupt, 11 isochronous) |
| ep_interval | input | 8*NUM_EP | Per-slot interval field (period for interrupt, exponent for isochronous) |
| ep_dir_in | input | NUM_EP | Per-slot direction, 1 = receive |
| ep_rx_req | input | NUM_EP | Receive request flags |
| ep_tx_rdy | input | NUM_EP | Transmit packet-ready flags |
| ep_tx_fifo_ne | input | NUM_EP | Transmit FIFO-not-empty flags |
| xact_done | input | 1 | Packet engine finished the granted transaction |
| frame_num | output | 11 | Current frame number |
| sof_req | output | 1 | Start-of-frame token request pulse |
| keepalive_req | output | 1 | Keep-alive K-state request pulse |
| grant | output | 1 | A transaction grant is open |
| grant_ep | output | log2(NUM_EP) | Index of the granted slot |

## Verification
A frame boundary and an open transaction can land in the same cycle. In that case the block must advance the frame and issue the token request while it keeps the current grant intact. The restart of the first pass is deferred until completion. The bench provokes this in two ways: it holds `xact_done` back and pulses `frame_tick` mid-grant, and it raises `frame_tick` and `xact_done` in the same cycle. In both cases it expects the unchanged grant to persist, then the next grant to go to slot 0 rather than the following index, with the due interrupt slot served again in the new first pass.

// File: rtl/usb_fsched_pkg.sv
// Shared types for the frame scheduler: slot transfer kinds and scan states.
package usb_fsched_pkg;
    typedef enum logic [1:0] {
        XFER_NONE = 2'b00,
        XFER_BULK = 2'b01,
        XFER_INTR = 2'b10,
        XFER_ISOC = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'b00,
        ST_SCAN  = 2'b01,
        ST_GRANT = 2'b10
    } sched_st_e;
endpackage

// File: rtl/usb_fsched_frame.sv
// Frame number keeper and per-frame token request.
// Assumes frame_tick is a single-cycle pulse; the request follows one cycle later.
module usb_fsched_frame #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_tick,
    input  logic               low_speed,
    output logic [FRAME_W-1:0] frame_num,
    output logic               sof_req,
    output logic               keepalive_req
);
    // Advance the frame number and raise the speed-dependent request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_num     <= '0;
            sof_req       <= 1'b0;
            keepalive_req <= 1'b0;
        end else begin
            sof_req       <= frame_tick & ~low_speed;
            keepalive_req <= frame_tick & low_speed;
            if (frame_tick) begin
                frame_num <= frame_num + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_fsched_slot.sv
// One endpoint slot: decodes activity and runs the interval counter.
// The counter reloads to period-1 on a frame where it is zero and otherwise
// counts down; the due flag captures whether the current frame is a service frame.
// Assumes IVL_W >= IVL_FIELD_W and IVL_W >= ISO_EXP_MAX.
module usb_fsched_slot
    import usb_fsched_pkg::*;
#(
    parameter int IVL_FIELD_W = 8,
    parameter int ISO_EXP_MAX = 16,
    parameter int IVL_W       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_tick,
    input  xfer_e                  xfer,
    input  logic [IVL_FIELD_W-1:0] ivl_field,
    input  logic                   dir_in,
    input  logic                   rx_req,
    input  logic                   tx_rdy,
    input  logic                   tx_fifo_ne,
    output logic                   active,
    output logic                   due
);
    localparam int EXP_W = $clog2(ISO_EXP_MAX + 1);

    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] reload;
    logic [IVL_W-1:0] one;
    logic [EXP_W-1:0] iso_exp;

    assign one = IVL_W'(1);

    // Activity from the direction-appropriate flags.
    assign active = (xfer != XFER_NONE) && (dir_in ? rx_req : (tx_rdy | tx_fifo_ne));

    // Clamp the isochronous exponent.
    assign iso_exp = (ivl_field > IVL_FIELD_W'(ISO_EXP_MAX)) ? EXP_W'(ISO_EXP_MAX)
                                                            : ivl_field[EXP_W-1:0];

    // Reload value (period minus one) for the configured kind.
    always_comb begin
        case (xfer)
            XFER_INTR: reload = (ivl_field == '0) ? '0
                                                  : IVL_W'(ivl_field - IVL_FIELD_W'(1));
            XFER_ISOC: reload = (one << iso_exp) - one;
            default:   reload = '0;
        endcase
    end

    // Count frames and latch the due flag at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (frame_tick) begin
            due <= (cnt == '0);
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/usb_fsched_scan.sv
// Scan engine: walks slots in ascending order, one grant at a time.
// Periodic slots count only on the first pass of a frame; a boundary during an
// open grant is remembered and applied when the grant completes.
module usb_fsched_scan
    import usb_fsched_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              xact_done,
    input  logic [NUM_EP-1:0] bulk_ok,
    input  logic [NUM_EP-1:0] per_ok,
    output logic              grant,
    output logic [IDX_W-1:0]  grant_ep
);
    sched_st_e        st;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nxt_idx;
    logic             first_pass;
    logic             pend;
    logic             last;
    logic             elig_now;

    assign last     = (idx == IDX_W'(NUM_EP - 1));
    assign nxt_idx  = last ? '0 : idx + 1'b1;
    assign elig_now = bulk_ok[idx] | (first_pass & per_ok[idx]);
    assign grant    = (st == ST_GRANT);
    assign grant_ep = idx;

    // Scan state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_WAIT;
            idx        <= '0;
            first_pass <= 1'b0;
            pend       <= 1'b0;
        end else begin
            case (st)
                ST_WAIT: begin
                    if (frame_tick) begin
                        st         <= ST_SCAN;
                        idx        <= '0;
                        first_pass <= 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (frame_tick) begin
                        idx        <= '0;
                        first_pass <= 1'b1;
                    end else if (elig_now) begin
                        st <= ST_GRANT;
                    end else begin
                        idx <= nxt_idx;
                        if (last) first_pass <= 1'b0;
                    end
                end
                ST_GRANT: begin
                    if (xact_done) begin
                        st   <= ST_SCAN;
                        pend <= 1'b0;
                        if (frame_tick || pend) begin
                            idx        <= '0;
                            first_pass <= 1'b1;
                        end else begin
                            idx <= nxt_idx;
                            if (last) first_pass <= 1'b0;
                        end
                    end else if (frame_tick) begin
                        pend <= 1'b1;
                    end
                end
                default: st <= ST_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/usb_frame_sched.sv
// Top: frame keeper, one slot per endpoint, and the scan engine.
// Assumes xact_done is only asserted while a grant is open.
module usb_frame_sched
    import usb_fsched_pkg::*;
#(
    parameter int NUM_EP      = 4,
    parameter int FRAME_W     = 11,
    parameter int IVL_FIELD_W = 8,
    parameter int ISO_EXP_MAX = 16,
    parameter int IDX_W       = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_tick,
    input  logic                          low_speed,
    input  logic [2*NUM_EP-1:0]           ep_type,
    input  logic [IVL_FIELD_W*NUM_EP-1:0] ep_interval,
    input  logic [NUM_EP-1:0]             ep_dir_in,
    input  logic [NUM_EP-1:0]             ep_rx_req,
    input  logic [NUM_EP-1:0]             ep_tx_rdy,
    input  logic [NUM_EP-1:0]             ep_tx_fifo_ne,
    input  logic                          xact_done,
    output logic [FRAME_W-1:0]            frame_num,
    output logic                          sof_req,
    output logic                          keepalive_req,
    output logic                          grant,
    output logic [IDX_W-1:0]              grant_ep
);
    localparam int IVL_W = (ISO_EXP_MAX > IVL_FIELD_W) ? ISO_EXP_MAX : IVL_FIELD_W;

    logic [NUM_EP-1:0] bulk_ok;
    logic [NUM_EP-1:0] per_ok;

    usb_fsched_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_tick    (frame_tick),
        .low_speed     (low_speed),
        .frame_num     (frame_num),
        .sof_req       (sof_req),
        .keepalive_req (keepalive_req)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
        xfer_e kind;
        logic  act;
        logic  due;

        assign kind = xfer_e'(ep_type[2*i +: 2]);

        usb_fsched_slot #(
            .IVL_FIELD_W (IVL_FIELD_W),
            .ISO_EXP_MAX (ISO_EXP_MAX),
            .IVL_W       (IVL_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_tick (frame_tick),
            .xfer       (kind),
            .ivl_field  (ep_interval[IVL_FIELD_W*i +: IVL_FIELD_W]),
            .dir_in     (ep_dir_in[i]),
            .rx_req     (ep_rx_req[i]),
            .tx_rdy     (ep_tx_rdy[i]),
            .tx_fifo_ne (ep_tx_fifo_ne[i]),
            .active     (act),
            .due        (due)
        );

        assign bulk_ok[i] = act && (kind == XFER_BULK);
        assign per_ok[i]  = act && due && (kind == XFER_INTR || kind == XFER_ISOC);
    end

    usb_fsched_scan #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .xact_done  (xact_done),
        .bulk_ok    (bulk_ok),
        .per_ok     (per_ok),
        .grant      (grant),
        .grant_ep   (grant_ep)
    );
endmodule

// File: rtl/usb_frame_sched_chk.sv
// Property checker for usb_frame_sched, attached by bind below.
module usb_frame_sched_chk #(
    parameter int NUM_EP  = 4,
    parameter int FRAME_W = 11,
    parameter int IDX_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_tick,
    input logic                low_speed,
    input logic [2*NUM_EP-1:0] ep_type,
    input logic [NUM_EP-1:0]   ep_dir_in,
    input logic [NUM_EP-1:0]   ep_rx_req,
    input logic [NUM_EP-1:0]   ep_tx_rdy,
    input logic [NUM_EP-1:0]   ep_tx_fifo_ne,
    input logic                xact_done,
    input logic [FRAME_W-1:0]  frame_num,
    input logic                sof_req,
    input logic                keepalive_req,
    input logic                grant,
    input logic [IDX_W-1:0]    grant_ep
);
    logic [NUM_EP-1:0] act_vec;
    logic              seen_tick;

    // Independent view of per-slot activity from the ports.
    always_comb begin
        for (int i = 0; i < NUM_EP; i++) begin
            act_vec[i] = (ep_type[2*i +: 2] != 2'b00) &&
                         (ep_dir_in[i] ? ep_rx_req[i] : (ep_tx_rdy[i] | ep_tx_fifo_ne[i]));
        end
    end

    // Remember whether any frame boundary has occurred since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_tick <= 1'b0;
        else if (frame_tick) seen_tick <= 1'b1;
    end

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(frame_tick)) |-> (frame_num == FRAME_W'($past(frame_num) + 1'b1))); // R1
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sof_req && keepalive_req)); // R2
    AST_SOF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sof_req |-> ($past(frame_tick) && !$past(low_speed))); // R2
    AST_KA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        keepalive_req |-> ($past(frame_tick) && $past(low_speed))); // R2
    AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(grant)) |-> $past(act_vec[grant_ep])); // R4
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !xact_done) |=> (grant && $stable(grant_ep))); // R9
    AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_tick |-> !grant); // R10
endmodule

bind usb_frame_sched usb_frame_sched_chk #(
    .NUM_EP  (NUM_EP),
    .FRAME_W (FRAME_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_tick    (frame_tick),
    .low_speed     (low_speed),
    .ep_type       (ep_type),
    .ep_dir_in     (ep_dir_in),
    .ep_rx_req     (ep_rx_req),
    .ep_tx_rdy     (ep_tx_rdy),
    .ep_tx_fifo_ne (ep_tx_fifo_ne),
    .xact_done     (xact_done),
    .frame_num     (frame_num),
    .sof_req       (sof_req),
    .keepalive_req (keepalive_req),
    .grant         (grant),
    .grant_ep      (grant_ep)
);

// File: tb/usb_frame_sched_test.sv
// Directed bench for usb_frame_sched: one task per scenario.
module usb_frame_sched_test;
    localparam int NUM_EP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        low_speed = 1'b0;
    logic [7:0]  ep_type = '0;
    logic [31:0] ep_interval = '0;
    logic [3:0]  ep_dir_in = '0;
    logic [3:0]  ep_rx_req = '0;
    logic [3:0]  ep_tx_rdy = '0;
    logic [3:0]  ep_tx_fifo_ne = '0;
    logic        xact_done = 1'b0;
    logic [10:0] frame_num;
    logic        sof_req;
    logic        keepalive_req;
    logic        grant;
    logic [1:0]  grant_ep;

    int total = 0;
    int bad = 0;
    int exp_frame = 0;

    usb_frame_sched uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .low_speed(low_speed),
        .ep_type(ep_type), .ep_interval(ep_interval), .ep_dir_in(ep_dir_in),
        .ep_rx_req(ep_rx_req), .ep_tx_rdy(ep_tx_rdy), .ep_tx_fifo_ne(ep_tx_fifo_ne),
        .xact_done(xact_done), .frame_num(frame_num), .sof_req(sof_req),
        .keepalive_req(keepalive_req), .grant(grant), .grant_ep(grant_ep)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_ep(input int i, input int kind, input int ivl, input bit din,
                          input bit rq, input bit rdy, input bit fne);
        ep_type[2*i +: 2]     = kind[1:0];
        ep_interval[8*i +: 8] = ivl[7:0];
        ep_dir_in[i]          = din;
        ep_rx_req[i]          = rq;
        ep_tx_rdy[i]          = rdy;
        ep_tx_fifo_ne[i]      = fne;
    endtask

    task automatic clear_eps();
        for (int i = 0; i < NUM_EP; i++) set_ep(i, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_tick = 1'b0;
        xact_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_frame = 0;
    endtask

    // One frame boundary; optionally checks frame number and request (R1, R2).
    task automatic tick(input bit chk);
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        exp_frame = (exp_frame + 1) % 2048;
        if (chk) begin
            check(frame_num == 11'(exp_frame), "R1", "frame_num", int'(frame_num), exp_frame);
            check(sof_req == !low_speed, "R2", "sof_req", int'(sof_req), int'(!low_speed));
            check(keepalive_req == low_speed, "R2", "keepalive_req",
                  int'(keepalive_req), int'(low_speed));
        end
    endtask

    task automatic wait_grant(output int ep, input int maxwait);
        ep = -1;
        for (int i = 0; i < maxwait; i++) begin
            @(negedge clk);
            if (grant) begin
                ep = int'(grant_ep);
                break;
            end
        end
    endtask

    task automatic give_done();
        xact_done = 1'b1;
        @(negedge clk);
        xact_done = 1'b0;
    endtask

    task automatic grab(output int ep);
        wait_grant(ep, 12);
        if (ep >= 0) give_done();
    endtask

    // Reset state and silence before the first frame.
    task automatic t_reset();
        clear_eps();
        set_ep(0, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_reset();
        check(frame_num == 0, "R1", "reset frame_num", int'(frame_num), 0);
        check(!sof_req && !keepalive_req, "R2", "reset requests",
              int'(sof_req | keepalive_req), 0);
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (grant) seen++;
            end
            check(seen == 0, "R10", "grants before first frame", seen, 0);
        end
    endtask

    // Requests for both speeds and pulse width.
    task automatic t_requests();
        clear_eps();
        do_reset();
        low_speed = 1'b0;
        tick(1'b1);
        @(negedge clk);
        check(!sof_req, "R2", "sof pulse width", int'(sof_req), 0);
        low_speed = 1'b1;
        tick(1'b1);
        @(negedge clk);
        check(!keepalive_req, "R2", "keepalive pulse width", int'(keepalive_req), 0);
        low_speed = 1'b0;
    endtask

    // Frame counter wrap.
    task automatic t_wrap();
        clear_eps();
        do_reset();
        for (int f = 0; f < 2047; f++) tick(1'b0);
        check(frame_num == 11'd2047, "R1", "frame before wrap", int'(frame_num), 2047);
        tick(1'b1);
        check(frame_num == 0, "R1", "frame after wrap", int'(frame_num), 0);
    endtask

    // Order, activity rules, unused slot, bulk every pass, hold.
    task automatic t_bulk_order();
        int ep;
        int exp_seq[6] = '{0, 1, 2, 0, 1, 2};
        clear_eps();
        set_ep(0, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        set_ep(1, 1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        set_ep(2, 1, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        set_ep(3, 0, 0, 1'b1, 1'b1, 1'b1, 1'b1);
        do_reset();
        tick(1'b0);
        wait_grant(ep, 12);
        check(ep == 0, "R9", "first grant", ep, 0);
        repeat (5) @(negedge clk);
        check(grant && grant_ep == 2'd0, "R9", "grant held without done", int'(grant_ep), 0);
        give_done();
        for (int k = 1; k < 6; k++) begin
            grab(ep);
            check(ep == exp_seq[k], "R5", "bulk order across passes", ep, exp_seq[k]);
        end
        // receive slot with only transmit flags set is not active; slot 3 unused
        set_ep(1, 1, 0, 1'b1, 1'b0, 1'b1, 1'b1);
        tick(1'b0);
        for (int k = 0; k < 4; k++) begin
            int e2 = (k % 2 == 0) ? 0 : 2;
            grab(ep);
            check(ep == e2, "R4", "inactive receive slot skipped", ep, e2);
        end
        check(ep != 3, "R3", "unused slot not granted", ep, 2);
        clear_eps();
        repeat (12) @(negedge clk);
    endtask

    // Interrupt periods 3 and 0 (treated as 1).
    task automatic t_interrupt();
        int ep;
        clear_eps();
        set_ep(0, 2, 3, 1'b1, 1'b1, 1'b0, 1'b0);
        set_ep(3, 2, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_reset();
        for (int f = 1; f <= 7; f++) begin
            int n0 = 0;
            int n3 = 0;
            tick(1'b0);
            for (int k = 0; k < 6; k++) begin
                grab(ep);
                if (ep == 0) n0++;
                if (ep == 3) n3++;
                if (ep < 0) break;
            end
            check(n0 == (((f - 1) % 3 == 0) ? 1 : 0), "R6", "interrupt period 3",
                  n0, ((f - 1) % 3 == 0) ? 1 : 0);
            check(n3 == 1, "R8", "interrupt period 1 once per frame", n3, 1);
        end
    endtask

    // Isochronous exponent 2 and clamped exponent 20.
    task automatic t_isoc();
        int ep;
        clear_eps();
        set_ep(1, 3, 2, 1'b0, 1'b0, 1'b1, 1'b0);
        set_ep(2, 3, 20, 1'b0, 1'b0, 1'b0, 1'b1);
        do_reset();
        for (int f = 1; f <= 9; f++) begin
            int n1 = 0;
            int n2 = 0;
            tick(1'b0);
            for (int k = 0; k < 6; k++) begin
                grab(ep);
                if (ep == 1) n1++;
                if (ep == 2) n2++;
                if (ep < 0) break;
            end
            check(n1 == (((f - 1) % 4 == 0) ? 1 : 0), "R7", "isoc exponent 2",
                  n1, ((f - 1) % 4 == 0) ? 1 : 0);
            check(n2 == ((f == 1) ? 1 : 0), "R7", "isoc exponent clamped",
                  n2, (f == 1) ? 1 : 0);
        end
    endtask

    // Periodic only on first pass while bulk continues.
    task automatic t_mix();
        int ep;
        int exp_seq[5] = '{0, 2, 0, 0, 0};
        clear_eps();
        set_ep(0, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        set_ep(2, 2, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        do_reset();
        for (int f = 0; f < 2; f++) begin
            tick(1'b0);
            for (int k = 0; k < 5; k++) begin
                grab(ep);
                check(ep == exp_seq[k], "R8", "periodic first pass only", ep, exp_seq[k]);
            end
        end
    endtask

    // Frame boundary during an open grant, and together with done.
    task automatic t_tick_in_grant();
        int ep;
        clear_eps();
        set_ep(0, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        set_ep(1, 1, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        set_ep(2, 2, 1, 1'b1, 1'b1, 1'b0, 1'b0);
        do_reset();
        tick(1'b0);
        grab(ep);
        check(ep == 0, "R9", "grant before boundary", ep, 0);
        wait_grant(ep, 12);
        check(ep == 1, "R9", "second grant", ep, 1);
        tick(1'b1);
        @(negedge clk);
        check(grant && grant_ep == 2'd1, "R11", "grant kept over boundary", int'(grant_ep), 1);
        give_done();
        grab(ep);
        check(ep == 0, "R11", "restart at slot 0 after done", ep, 0);
        grab(ep);
        check(ep == 1, "R11", "new pass slot 1", ep, 1);
        grab(ep);
        check(ep == 2, "R11", "periodic served in new first pass", ep, 2);
        wait_grant(ep, 12);
        check(ep == 0, "R5", "bulk in later pass", ep, 0);
        @(negedge clk);
        frame_tick = 1'b1;
        xact_done = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        xact_done = 1'b0;
        exp_frame = (exp_frame + 1) % 2048;
        check(frame_num == 11'(exp_frame), "R1", "frame with simultaneous done",
              int'(frame_num), exp_frame);
        grab(ep);
        check(ep == 0, "R11", "restart when boundary meets done", ep, 0);
        grab(ep);
        check(ep == 1, "R11", "next after restart", ep, 1);
        grab(ep);
        check(ep == 2, "R11", "periodic after simultaneous boundary", ep, 2);
    endtask

    initial begin
        t_reset();
        t_requests();
        t_wrap();
        t_bulk_order();
        t_interrupt();
        t_isoc();
        t_mix();
        t_tick_in_grant();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule